// File: doc/BRIEF.md
# Byte Mailbox Host Port

This block is a small register window that lets a host bus exchange single bytes with an embedded controller. Each direction has a one-byte holding slot. The controller pushes bytes toward the host through a valid/ready pair, and the host collects them by reading the data offset. The host posts bytes toward the controller by writing the transmit offset, and the controller drains them through a second valid/ready pair.

Two status offsets let software poll the slots. One reports that a received byte is waiting, and the other reports that the transmit slot is free. Both flags sit in bit 0. A control offset drives a reset line into the controller. Writes to the input-status offset also set or clear an interrupt enable. Every write, at any offset, is captured in an echo register that software can read back. A revision byte is fixed by a parameter.

Host accesses are single-cycle strobes. Read data is combinational from the current state, and the side effects of an access take hold at the clock edge that samples the strobe.

Top module: `mbox_host_port`

## Requirements
- R1: After reset, in-status (0x02) bit 0 reads 0, out-status (0x03) bit 0 reads 1, `irq` and `ctl_rst` are 0, the echo register (0x04) reads 0x00 and the receive data offset (0x00) reads 0x00.
- R2: When the receive slot is empty, `c2h_ready` is 1. A byte offered with `c2h_valid` is then taken at that edge. From the next cycle, `c2h_ready` is 0, in-status bit 0 reads 1 and offset 0x00 returns the byte. While the slot is full, offered bytes are not taken.
- R3: A host read strobe at offset 0x00 while the receive slot is full empties the slot at that edge, so in-status bit 0 is 0 and `c2h_ready` is 1 on the next cycle. Offset 0x00 keeps returning the last received byte.
- R4: A host write to offset 0x01 while the transmit slot is empty loads the byte. From the next cycle, out-status bit 0 reads 0 and `h2c_valid` is 1 with the byte on `h2c_data`. Both hold until an edge where `h2c_ready` is 1.
- R5: A host write to offset 0x01 while the transmit slot is full and `h2c_ready` is 0 is discarded, and `h2c_data` keeps the earlier byte.
- R6: A host write to offset 0x01 in the same cycle that the controller drains the transmit slot (`h2c_valid` and `h2c_ready` both 1) is accepted. On the next cycle, `h2c_valid` stays 1 with the new byte and out-status bit 0 stays 0.
- R7: A write to offset 0x02 sets the interrupt enable to bit 1 of the written byte, so 0x02 enables and 0x00 disables. `irq` equals receive-full AND enable.
- R8: A write to offset 0x10 sets `ctl_rst` to bit 0 of the written byte from the next cycle. Reading 0x10 returns that value in bit 0.
- R9: Every host write, at any offset, stores its byte in the echo register, which reads back at offset 0x04 from the next cycle.
- R10: Offset 0x05 reads the constant given by parameter `REVISION`.
- R11: Reads of offset 0x01 and of any unmapped offset return 0x00. Writes to offsets 0x03, 0x05 or unmapped offsets change nothing except the echo register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Register offset |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data for `host_addr` |
| irq | output | 1 | Interrupt toward host |
| ctl_rst | output | 1 | Reset line into the controller |
| c2h_valid | input | 1 | Controller offers a byte |
| c2h_data | input | DATA_W | Byte from controller |
| c2h_ready | output | 1 | Receive slot can take a byte |
| h2c_valid | output | 1 | Transmit slot holds a byte |
| h2c_data | output | DATA_W | Byte toward controller |
| h2c_ready | input | 1 | Controller takes the byte |

## Verification
The transmit slot can be drained by the controller and refilled by the host in the same cycle. The bench provokes this by issuing a host write to 0x01 while `h2c_ready` is high over a full slot. The reference model must then show the new byte on `h2c_data` with the free flag still low. A second collision pairs a receive-data read with a controller offer: the bench holds `c2h_valid` across the read, so the waiting byte must be taken on the cycle after the slot empties, never on the read cycle. A long stretch of mixed random strobes then hits both collisions repeatedly, with every output compared to the model on every clock.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int OFF_RXD   = 'h00;
  localparam int OFF_TXD   = 'h01;
  localparam int OFF_INST  = 'h02;
  localparam int OFF_OUTST = 'h03;
  localparam int OFF_ECHO  = 'h04;
  localparam int OFF_REV   = 'h05;
  localparam int OFF_CRST  = 'h10;

  localparam int IEN_BIT   = 1;

  typedef enum logic [2:0] {
    SEL_RXD,
    SEL_TXD,
    SEL_INST,
    SEL_OUTST,
    SEL_ECHO,
    SEL_REV,
    SEL_CRST,
    SEL_NONE
  } mbox_sel_e;

endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mbox_regdec.sv
module mbox_regdec
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output mbox_sel_e         sel,
  output logic              rd_rxd,
  output logic              wr_txd,
  output logic              wr_inst,
  output logic              wr_crst,
  output logic              wr_any
);

  always_comb begin
    if (addr == ADDR_W'(OFF_RXD))        sel = SEL_RXD;
    else if (addr == ADDR_W'(OFF_TXD))   sel = SEL_TXD;
    else if (addr == ADDR_W'(OFF_INST))  sel = SEL_INST;
    else if (addr == ADDR_W'(OFF_OUTST)) sel = SEL_OUTST;
    else if (addr == ADDR_W'(OFF_ECHO))  sel = SEL_ECHO;
    else if (addr == ADDR_W'(OFF_REV))   sel = SEL_REV;
    else if (addr == ADDR_W'(OFF_CRST))  sel = SEL_CRST;
    else                                 sel = SEL_NONE;
  end

  always_comb begin
    rd_rxd  = rd && (sel == SEL_RXD);
    wr_txd  = wr && (sel == SEL_TXD);
    wr_inst = wr && (sel == SEL_INST);
    wr_crst = wr && (sel == SEL_CRST);
    wr_any  = wr;
  end

endmodule

// File: rtl/mbox_slot.sv
module mbox_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              unload,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              full_en, data_en;

  always_comb begin
    full_en = load || unload;
    full_d  = load || (full_q && !unload);
    data_en = load;
    data_d  = load_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (full_en) begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  assign full = full_q;
  assign data = data_q;

endmodule

// File: rtl/mbox_ctrl_regs.sv
module mbox_ctrl_regs
  import mbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_any,
  input  logic              wr_inst,
  input  logic              wr_crst,
  input  logic [DATA_W-1:0] wdata,
  output logic              irq_en,
  output logic              ctl_rst,
  output logic [DATA_W-1:0] echo
);

  logic              ien_q, ien_d;
  logic              crst_q, crst_d;
  logic [DATA_W-1:0] echo_q, echo_d;

  always_comb begin
    ien_d  = wdata[IEN_BIT];
    crst_d = wdata[0];
    echo_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
    end else if (wr_inst) begin
      ien_q <= ien_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crst_q <= 1'b0;
    end else if (wr_crst) begin
      crst_q <= crst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      echo_q <= '0;
    end else if (wr_any) begin
      echo_q <= echo_d;
    end
  end

  assign irq_en  = ien_q;
  assign ctl_rst = crst_q;
  assign echo    = echo_q;

endmodule

// File: rtl/mbox_host_port.sv
module mbox_host_port
  import mbox_pkg::*;
#(
  parameter int                ADDR_W   = 5,
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] REVISION = 8'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq,
  output logic              ctl_rst,
  input  logic              c2h_valid,
  input  logic [DATA_W-1:0] c2h_data,
  output logic              c2h_ready,
  output logic              h2c_valid,
  output logic [DATA_W-1:0] h2c_data,
  input  logic              h2c_ready
);

  localparam int PAD_W = DATA_W - 1;

  logic              rst_sync_n;
  mbox_sel_e         sel;
  logic              rd_rxd, wr_txd, wr_inst, wr_crst, wr_any;
  logic              rx_full, tx_full;
  logic [DATA_W-1:0] rx_data, tx_data, echo;
  logic              irq_en;
  logic              rx_load, rx_unload, tx_load, tx_unload;

  mbox_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mbox_regdec #(.ADDR_W(ADDR_W)) u_regdec (
    .addr    (host_addr),
    .wr      (host_wr),
    .rd      (host_rd),
    .sel     (sel),
    .rd_rxd  (rd_rxd),
    .wr_txd  (wr_txd),
    .wr_inst (wr_inst),
    .wr_crst (wr_crst),
    .wr_any  (wr_any)
  );

  always_comb begin
    rx_load   = c2h_valid && !rx_full;
    rx_unload = rd_rxd && rx_full;
    tx_unload = h2c_ready && tx_full;
    tx_load   = wr_txd && (!tx_full || tx_unload);
  end

  mbox_slot #(.DATA_W(DATA_W)) u_rx_slot (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (rx_load),
    .load_data (c2h_data),
    .unload    (rx_unload),
    .full      (rx_full),
    .data      (rx_data)
  );

  mbox_slot #(.DATA_W(DATA_W)) u_tx_slot (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (tx_load),
    .load_data (host_wdata),
    .unload    (tx_unload),
    .full      (tx_full),
    .data      (tx_data)
  );

  mbox_ctrl_regs #(.DATA_W(DATA_W)) u_ctrl_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_any  (wr_any),
    .wr_inst (wr_inst),
    .wr_crst (wr_crst),
    .wdata   (host_wdata),
    .irq_en  (irq_en),
    .ctl_rst (ctl_rst),
    .echo    (echo)
  );

  always_comb begin
    case (sel)
      SEL_RXD:   host_rdata = rx_data;
      SEL_INST:  host_rdata = {{PAD_W{1'b0}}, rx_full};
      SEL_OUTST: host_rdata = {{PAD_W{1'b0}}, !tx_full};
      SEL_ECHO:  host_rdata = echo;
      SEL_REV:   host_rdata = REVISION;
      SEL_CRST:  host_rdata = {{PAD_W{1'b0}}, ctl_rst};
      default:   host_rdata = '0;
    endcase
  end

  assign irq       = rx_full && irq_en;
  assign c2h_ready = !rx_full;
  assign h2c_valid = tx_full;
  assign h2c_data  = tx_data;

endmodule

// File: rtl/mbox_host_port_chk.sv
module mbox_host_port_chk
  import mbox_pkg::*;
#(
  parameter int                ADDR_W   = 5,
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] REVISION = 8'h2A
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic [DATA_W-1:0] host_wdata,
  input logic [DATA_W-1:0] host_rdata,
  input logic              irq,
  input logic              ctl_rst,
  input logic              c2h_valid,
  input logic              c2h_ready,
  input logic              h2c_valid,
  input logic [DATA_W-1:0] h2c_data,
  input logic              h2c_ready
);

  p_rx_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (c2h_valid && c2h_ready) |=> !c2h_ready);

  p_rx_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == ADDR_W'(OFF_RXD) && !c2h_ready) |=> c2h_ready);

  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (h2c_valid && !h2c_ready) |=> (h2c_valid && $stable(h2c_data)));

  p_tx_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (h2c_valid && h2c_ready && host_wr && host_addr == ADDR_W'(OFF_TXD))
      |=> (h2c_valid && h2c_data == $past(host_wdata)));

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !c2h_ready);

  p_ctl_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == ADDR_W'(OFF_CRST)) |=> (ctl_rst == $past(host_wdata[0])));

  p_echo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (host_addr != ADDR_W'(OFF_ECHO) || host_rdata == $past(host_wdata)));

  p_rev_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == ADDR_W'(OFF_REV)) |-> (host_rdata == REVISION));

endmodule

bind mbox_host_port mbox_host_port_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .REVISION (REVISION)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .irq        (irq),
  .ctl_rst    (ctl_rst),
  .c2h_valid  (c2h_valid),
  .c2h_ready  (c2h_ready),
  .h2c_valid  (h2c_valid),
  .h2c_data   (h2c_data),
  .h2c_ready  (h2c_ready)
);

// File: tb/tb_mbox_host_port.sv
module tb_mbox_host_port;

  localparam int         ADDR_W = 5;
  localparam int         DATA_W = 8;
  localparam logic [7:0] REV    = 8'h2A;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] host_addr;
  logic              host_wr, host_rd;
  logic [DATA_W-1:0] host_wdata;
  logic [DATA_W-1:0] host_rdata;
  logic              irq, ctl_rst;
  logic              c2h_valid;
  logic [DATA_W-1:0] c2h_data;
  logic              c2h_ready;
  logic              h2c_valid;
  logic [DATA_W-1:0] h2c_data;
  logic              h2c_ready;

  int n_chk;
  int n_bad;

  // reference model state
  int rx_q[$];
  int tx_q[$];
  int rx_last;
  int ien_m, crst_m, echo_m;

  mbox_host_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REVISION(REV)) dut (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .ctl_rst(ctl_rst),
    .c2h_valid(c2h_valid), .c2h_data(c2h_data), .c2h_ready(c2h_ready),
    .h2c_valid(h2c_valid), .h2c_data(h2c_data), .h2c_ready(h2c_ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int exp_rdata(input int a);
    case (a)
      'h00: return rx_last;
      'h02: return (rx_q.size() != 0) ? 1 : 0;
      'h03: return (tx_q.size() == 0) ? 1 : 0;
      'h04: return echo_m;
      'h05: return int'(REV);
      'h10: return crst_m;
      default: return 0;
    endcase
  endfunction

  // one clock: drive, compare before the edge, advance model
  task automatic step(input int a, input bit w, input bit r, input int wd,
                      input bit cv, input int cd, input bit hr, input string tag);
    bit rx_un, rx_ld, tx_dr, tx_ac;
    host_addr  = ADDR_W'(a);
    host_wr    = w;
    host_rd    = r;
    host_wdata = DATA_W'(wd);
    c2h_valid  = cv;
    c2h_data   = DATA_W'(cd);
    h2c_ready  = hr;
    #2;
    chk(tag, "c2h_ready", int'(c2h_ready), (rx_q.size() == 0) ? 1 : 0);
    chk(tag, "h2c_valid", int'(h2c_valid), (tx_q.size() != 0) ? 1 : 0);
    if (tx_q.size() != 0) chk(tag, "h2c_data", int'(h2c_data), tx_q[0]);
    chk(tag, "irq", int'(irq), (rx_q.size() != 0 && ien_m != 0) ? 1 : 0);
    chk(tag, "ctl_rst", int'(ctl_rst), crst_m);
    chk(tag, "host_rdata", int'(host_rdata), exp_rdata(a));
    rx_un = r && (a == 'h00) && (rx_q.size() != 0);
    rx_ld = cv && (rx_q.size() == 0);
    tx_dr = hr && (tx_q.size() != 0);
    tx_ac = w && (a == 'h01) && ((tx_q.size() == 0) || tx_dr);
    if (rx_un) void'(rx_q.pop_front());
    if (rx_ld) begin rx_q.push_back(cd & 'hFF); rx_last = cd & 'hFF; end
    if (tx_dr) void'(tx_q.pop_front());
    if (tx_ac) tx_q.push_back(wd & 'hFF);
    if (w && a == 'h02) ien_m = (wd >> 1) & 1;
    if (w && a == 'h10) crst_m = wd & 1;
    if (w) echo_m = wd & 'hFF;
    @(negedge clk);
  endtask

  task automatic idle(input int a, input string tag);
    step(a, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rx_last = 0; ien_m = 0; crst_m = 0; echo_m = 0;
    host_addr = '0; host_wr = 0; host_rd = 0; host_wdata = '0;
    c2h_valid = 0; c2h_data = '0; h2c_ready = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset values across the readable offsets
    idle('h02, "R1"); idle('h03, "R1"); idle('h04, "R1");
    idle('h10, "R1"); idle('h00, "R1");
    // R10: revision constant
    idle('h05, "R10");

    // R2: controller byte fills the receive slot, second offer waits
    step('h02, 0, 0, 0, 1, 'h5A, 0, "R2");
    step('h02, 0, 0, 0, 1, 'h77, 0, "R2");
    step('h00, 0, 0, 0, 1, 'h77, 0, "R2");
    // R3: read empties slot, held offer lands one cycle later
    step('h00, 0, 1, 0, 1, 'h77, 0, "R3");
    step('h00, 0, 0, 0, 1, 'h77, 0, "R3");
    step('h02, 0, 0, 0, 0, 0, 0, "R3");
    step('h00, 0, 1, 0, 0, 0, 0, "R3");
    idle('h00, "R3");
    step('h00, 0, 1, 0, 0, 0, 0, "R3");

    // R7: interrupt enable through in-status writes
    step('h02, 1, 0, 'h02, 0, 0, 0, "R7");
    step('h02, 0, 0, 0, 1, 'h3C, 0, "R7");
    idle('h02, "R7");
    step('h02, 1, 0, 'h00, 0, 0, 0, "R7");
    idle('h02, "R7");
    step('h02, 1, 0, 'h02, 0, 0, 0, "R7");
    step('h00, 0, 1, 0, 0, 0, 0, "R7");
    idle('h02, "R7");

    // R4: host byte waits in transmit slot
    step('h01, 1, 0, 'hC3, 0, 0, 0, "R4");
    idle('h03, "R4");
    idle('h03, "R4");
    // R5: write into a full, stalled slot is dropped
    step('h01, 1, 0, 'h11, 0, 0, 0, "R5");
    idle('h03, "R5");
    // R6: write on the drain cycle is kept
    step('h01, 1, 0, 'h99, 0, 0, 1, "R6");
    idle('h03, "R6");
    step('h03, 0, 0, 0, 0, 0, 1, "R6");
    idle('h03, "R6");

    // R8: controller reset line
    step('h10, 1, 0, 'h01, 0, 0, 0, "R8");
    idle('h10, "R8");
    step('h10, 1, 0, 'hFE, 0, 0, 0, "R8");
    idle('h10, "R8");

    // R9: echo from writes at various offsets
    step('h05, 1, 0, 'hEE, 0, 0, 0, "R9");
    idle('h04, "R9");
    step('h13, 1, 0, 'h4B, 0, 0, 0, "R9");
    idle('h04, "R9");

    // R11: unmapped and write-only offsets read zero, read-only writes inert
    idle('h01, "R11");
    idle('h07, "R11");
    idle('h1F, "R11");
    step('h03, 1, 0, 'h00, 0, 0, 0, "R11");
    idle('h03, "R11");

    // R6: mixed traffic, collisions on both slots
    for (int i = 0; i < 400; i++) begin
      int a;
      int pick = $urandom_range(0, 7);
      case (pick)
        0: a = 'h00; 1: a = 'h01; 2: a = 'h02; 3: a = 'h03;
        4: a = 'h04; 5: a = 'h05; 6: a = 'h10; default: a = 'h0B;
      endcase
      step(a, ($urandom_range(0, 2) == 0), ($urandom_range(0, 1) == 1),
           $urandom_range(0, 255), ($urandom_range(0, 1) == 1),
           $urandom_range(0, 255), ($urandom_range(0, 2) != 0), "R6");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule